// File: doc/BRIEF.md
# Two-Wire Debug Link Master

This block is the host side of a two-wire debug port on a small 8-bit microcontroller. The host drives the debug clock by itself and shares one data line with the target. It also drives the target's reset line. The block can run the entry sequence that puts the target into debug mode. It can also run a command transfer: one command byte and zero to three argument bytes go out, then the line is turned around and one response byte comes back.

A request is given by pulsing `start_i` while the block is idle. Alongside it the requester supplies the command byte, the argument count, the packed arguments and two flags. One flag says whether a response byte is expected. The other says whether the command is a status read, whose lock bit should be exported. The block holds `busy_o` high for the whole transfer. When it finishes it raises `done_o` for one cycle, and in that same cycle `busy_o` is low and the response byte is valid.

The data line is presented as three signals: an output value, an output enable and an input. The pad or the surrounding logic merges them into one wire, which idles high through a pull-up.

Top module: `dbg_link_master`

## Requirements
- R1: After reset the outputs are as follows. `busy_o`, `done_o`, `dbg_clk_o`, `dbg_data_oe_o` and `locked_o` are 0. `tgt_rst_no` is 1. `resp_o` is 0.
- R2: An accepted request with `entry_i`=1 pulls `tgt_rst_no` low. While reset is low it gives exactly two debug clock pulses. It then releases reset before `done_o`. It produces no data traffic.
- R3: Outgoing bytes are sent MSB first. The data value changes only in the cycle where the debug clock rises, and it stays stable while the clock is high. The target samples on the falling edge.
- R4: `arg_cnt_i` (0 to 3) sets how many argument bytes follow the command byte. `args_i[23:16]` is the first argument, `args_i[15:8]` the second and `args_i[7:0]` the third. Exactly 8×(1+count) clock pulses are sent.
- R5: When a response is expected, the host stops driving data after the last outgoing bit. It then gives no clock pulse until the target has pulled the data line low.
- R6: The response consists of 8 bits, MSB first, and each bit is sampled at a falling clock edge. The byte appears on `resp_o` in the cycle where `done_o` is high.
- R7: With `resp_en_i`=0 the transfer ends after the last outgoing bit. No further clock pulses are sent, and `resp_o` keeps its previous value.
- R8: `busy_o` rises in the cycle after acceptance and stays high until completion. `done_o` is a one-cycle pulse and `busy_o` is low in that cycle. A `start_i` seen while busy is ignored. A `start_i` seen in the `done_o` cycle is accepted.
- R9: `locked_o` is loaded from bit LOCK_BIT of the response, and only when a transfer flagged with `status_i` completes. All other transfers leave it unchanged.
- R10: Every high phase of the debug clock lasts exactly HALF_CYC system cycles, and the clock stays low while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when idle |
| entry_i | input | 1 | Request is the debug-mode entry sequence |
| cmd_i | input | 8 | Command byte |
| arg_cnt_i | input | 2 | Number of argument bytes, 0 to 3 |
| args_i | input | 24 | Argument bytes, first argument in the top byte |
| resp_en_i | input | 1 | Read a response byte after sending |
| status_i | input | 1 | Response is a status byte; update the lock flag |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| resp_o | output | 8 | Last response byte |
| locked_o | output | 1 | Lock flag from the last status read |
| dbg_clk_o | output | 1 | Debug clock to the target |
| dbg_data_o | output | 1 | Data value driven by the host |
| dbg_data_oe_o | output | 1 | Host data driver enable |
| dbg_data_i | input | 1 | Data line as seen by the host |
| tgt_rst_no | output | 1 | Target reset, active low |

## Verification
Two events can fall in the same cycle: the completion of one transfer, with `done_o` high and the response presented, and the acceptance of the next request. The bench provokes this by holding `start_i` high from one request into the next, with a different command presented after the first acceptance. The scoreboard then expects two things. The first transfer's bytes must arrive unaltered, because the held strobe is ignored while busy. The second command must start right after the first completion, with both completions reporting their own response and lock values.

// File: rtl/dbg_link_pkg.sv
package dbg_link_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned MAX_ARGS = 3;
  localparam int unsigned FRAME_W  = BYTE_W * (MAX_ARGS + 1);
  localparam int unsigned ENTRY_LAST = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENTRY,
    ST_TX,
    ST_TURN,
    ST_WAIT,
    ST_RX
  } link_state_e;
endpackage

// File: rtl/dbg_tick_gen.sv
module dbg_tick_gen #(
  parameter int unsigned HALF_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(HALF_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(HALF_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dbg_shift_reg.sv
module dbg_shift_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         ser_i,
  output logic         msb_o,
  output logic [7:0]   low_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= load_val_i;
    else if (shift_i) sr_q <= {sr_q[W-2:0], ser_i};
  end

  assign msb_o = sr_q[W-1];
  assign low_o = sr_q[7:0];
endmodule

// File: rtl/dbg_link_master.sv
module dbg_link_master
  import dbg_link_pkg::*;
#(
  parameter int unsigned HALF_CYC = 4,
  parameter int unsigned LOCK_BIT = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        entry_i,
  input  logic [7:0]  cmd_i,
  input  logic [1:0]  arg_cnt_i,
  input  logic [23:0] args_i,
  input  logic        resp_en_i,
  input  logic        status_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [7:0]  resp_o,
  output logic        locked_o,
  output logic        dbg_clk_o,
  output logic        dbg_data_o,
  output logic        dbg_data_oe_o,
  input  logic        dbg_data_i,
  output logic        tgt_rst_no
);
  localparam int unsigned BCW = $clog2(FRAME_W);

  link_state_e    state_q;
  logic           ph_q;
  logic [BCW-1:0] bcnt_q;
  logic [2:0]     ecnt_q;
  logic [1:0]     nargs_q;
  logic           rsp_q, stat_q, done_q, lock_q;
  logic [7:0]     resp_q;

  logic           tick, accept, load, shift, ser_in, sr_msb;
  logic [7:0]     sr_low;
  logic [BCW-1:0] last_bit;

  assign accept   = (state_q == ST_IDLE) && start_i;
  assign load     = accept && !entry_i;
  assign shift    = tick && (((state_q == ST_TX) && ph_q) || ((state_q == ST_RX) && !ph_q));
  assign ser_in   = (state_q == ST_RX) && dbg_data_i;
  assign last_bit = BCW'({nargs_q, 3'b111});

  dbg_tick_gen #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q != ST_IDLE),
    .tick_o (tick)
  );

  dbg_shift_reg #(.W(FRAME_W)) u_sr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i ({cmd_i, args_i}),
    .shift_i    (shift),
    .ser_i      (ser_in),
    .msb_o      (sr_msb),
    .low_o      (sr_low)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= 1'b0;
      bcnt_q  <= '0;
      ecnt_q  <= '0;
      nargs_q <= '0;
      rsp_q   <= 1'b0;
      stat_q  <= 1'b0;
      done_q  <= 1'b0;
      lock_q  <= 1'b0;
      resp_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= entry_i ? ST_ENTRY : ST_TX;
          ph_q    <= 1'b0;
          bcnt_q  <= '0;
          ecnt_q  <= '0;
          nargs_q <= arg_cnt_i;
          rsp_q   <= resp_en_i;
          stat_q  <= status_i;
        end
        ST_ENTRY: if (tick) begin
          if (ecnt_q == 3'(ENTRY_LAST)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            ecnt_q <= ecnt_q + 1'b1;
          end
        end
        ST_TX: if (tick) begin
          ph_q <= !ph_q;
          if (ph_q) begin
            if (bcnt_q == last_bit) begin
              bcnt_q <= '0;
              if (rsp_q) state_q <= ST_TURN;
              else begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
            end
          end
        end
        ST_TURN: if (tick) state_q <= ST_WAIT;
        // target signals ready by pulling data low
        ST_WAIT: if (tick && !dbg_data_i) begin
          state_q <= ST_RX;
          ph_q    <= 1'b0;
        end
        ST_RX: if (tick) begin
          ph_q <= !ph_q;
          if (ph_q) begin
            if (bcnt_q == BCW'(7)) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              resp_q  <= sr_low;
              if (stat_q) lock_q <= sr_low[LOCK_BIT];
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = state_q != ST_IDLE;
  assign done_o        = done_q;
  assign resp_o        = resp_q;
  assign locked_o      = lock_q;
  assign dbg_clk_o     = (((state_q == ST_TX) || (state_q == ST_RX)) && !ph_q) ||
                         ((state_q == ST_ENTRY) && ((ecnt_q == 3'd1) || (ecnt_q == 3'd3)));
  assign dbg_data_oe_o = state_q == ST_TX;
  assign dbg_data_o    = (state_q == ST_TX) && sr_msb;
  assign tgt_rst_no    = !((state_q == ST_ENTRY) && (ecnt_q != 3'(ENTRY_LAST)));
endmodule

// File: rtl/dbg_link_chk.sv
module dbg_link_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic dbg_clk_o,
  input logic dbg_data_o,
  input logic dbg_data_oe_o,
  input logic tgt_rst_no
);
  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  // R2
  rst_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tgt_rst_no);

  // R10
  clk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !dbg_clk_o);

  // R3
  data_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_data_oe_o && $past(dbg_data_oe_o) && !$stable(dbg_data_o)) |-> $rose(dbg_clk_o));

  // R2
  entry_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tgt_rst_no |-> !dbg_data_oe_o);
endmodule

bind dbg_link_master dbg_link_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .dbg_clk_o     (dbg_clk_o),
  .dbg_data_o    (dbg_data_o),
  .dbg_data_oe_o (dbg_data_oe_o),
  .tgt_rst_no    (tgt_rst_no)
);

// File: tb/sim_dbg_link_master.sv
module sim_dbg_link_master;
  localparam int HALF = 4;
  localparam int LOCKB = 2;
  localparam int RDY_DLY = 11;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic        start = 1'b0, entry = 1'b0, resp_en = 1'b0, status = 1'b0;
  logic [7:0]  cmd = '0;
  logic [1:0]  arg_cnt = '0;
  logic [23:0] args = '0;
  logic        busy, done, locked, dclk, dout, doe, rst_n_t;
  logic [7:0]  resp;
  logic        tdrv = 1'b0, tbit = 1'b1;
  wire         line = doe ? dout : (tdrv ? tbit : 1'b1);

  dbg_link_master #(.HALF_CYC(HALF), .LOCK_BIT(LOCKB)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .entry_i(entry),
    .cmd_i(cmd), .arg_cnt_i(arg_cnt), .args_i(args), .resp_en_i(resp_en),
    .status_i(status), .busy_o(busy), .done_o(done), .resp_o(resp),
    .locked_o(locked), .dbg_clk_o(dclk), .dbg_data_o(dout),
    .dbg_data_oe_o(doe), .dbg_data_i(line), .tgt_rst_no(rst_n_t)
  );

  int errs = 0, checks = 0, cyc = 0;
  always @(negedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct { logic [7:0] r; logic l; } done_t;
  logic [7:0] exp_q[$];
  done_t      done_q[$];
  logic [7:0] mresp = '0;
  logic       mlock = 1'b0;

  // target model
  logic [7:0] tgt_resp = '0;
  bit         want_resp = 0, waiting = 0;
  int         rises = 0, ent_fall = 0, rxn = 0, rise_t = 0;
  logic [7:0] rxb = '0;

  always @(posedge dclk) begin
    rises++;
    rise_t = cyc;
    if (waiting) chk(0, "R5 clock before ready", 1, 0);
  end

  always @(negedge dclk) begin
    chk(cyc - rise_t == HALF, "R10 high phase", cyc - rise_t, HALF);
    if (!rst_n_t) ent_fall++;
    else if (doe) begin
      rxb = {rxb[6:0], line};
      rxn++;
      if (rxn == 8) begin
        rxn = 0;
        if (exp_q.size() == 0) chk(0, "R4 extra byte", rxb, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rxb == e, "R3 sent byte", rxb, e);
        end
      end
    end
  end

  initial forever begin
    @(negedge doe);
    #1;
    if (want_resp && busy) begin
      waiting = 1;
      repeat (RDY_DLY) @(posedge clk);
      #1;
      waiting = 0;
      tdrv = 1; tbit = 1'b0;
      for (int i = 7; i >= 0; i--) begin
        @(posedge dclk);
        tbit = tgt_resp[i];
      end
      @(negedge dclk);
      tdrv = 0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && done) begin
      if (done_q.size() == 0) chk(0, "R8 spurious done", 1, 0);
      else begin
        done_t d;
        d = done_q.pop_front();
        chk(resp == d.r, "R6 R7 response", resp, d.r);
        chk(locked == d.l, "R9 lock flag", locked, d.l);
        chk(!busy, "R8 busy low at done", busy, 0);
      end
    end
  end

  task automatic push_exp(input logic [7:0] c, input int n, input logic [23:0] a,
                          input bit re, input bit st, input logic [7:0] tr);
    exp_q.push_back(c);
    for (int i = 0; i < n; i++) exp_q.push_back(a[23-8*i -: 8]);
    if (re) begin
      mresp = tr;
      if (st) mlock = tr[LOCKB];
    end
    done_q.push_back('{mresp, mlock});
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic run_cmd(input logic [7:0] c, input int n, input logic [23:0] a,
                         input bit re, input bit st, input logic [7:0] tr);
    push_exp(c, n, a, re, st, tr);
    want_resp = re; tgt_resp = tr; rises = 0;
    @(negedge clk);
    start = 1; entry = 0; cmd = c; arg_cnt = 2'(n); args = a; resp_en = re; status = st;
    @(negedge clk);
    chk(busy, "R8 busy after accept", busy, 1);
    // strobe while busy must be ignored
    cmd = 8'hEE; arg_cnt = 2'd3;
    @(negedge clk);
    start = 0;
    wait_done();
    chk(rises == 8 * (n + 1) + (re ? 8 : 0), "R4 R7 clock pulses", rises, 8 * (n + 1) + (re ? 8 : 0));
    chk(exp_q.size() == 0, "R4 bytes sent", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !dclk && !doe && !locked, "R1 reset outputs", {busy, done, dclk, doe, locked}, 0);
    chk(rst_n_t && resp == 8'h00, "R1 reset line and resp", {rst_n_t, resp}, 9'h100);
    rst_ni = 1;
    repeat (2) @(negedge clk);

    // R2 entry sequence
    ent_fall = 0;
    done_q.push_back('{mresp, mlock});
    start = 1; entry = 1;
    @(negedge clk);
    start = 0; entry = 0;
    chk(!rst_n_t, "R2 reset pulled low", rst_n_t, 0);
    wait_done();
    chk(ent_fall == 2, "R2 pulses under reset", ent_fall, 2);
    chk(rst_n_t, "R2 reset released", rst_n_t, 1);

    run_cmd(8'h34, 0, 24'h0, 1, 1, 8'h04);          // status read, lock=1
    run_cmd(8'h55, 3, 24'h90A1C3, 1, 0, 8'h9C);     // three args, lock holds
    run_cmd(8'h3C, 1, 24'hC30000, 0, 0, 8'h11);     // no response, resp holds
    run_cmd(8'h81, 2, 24'h800100, 1, 1, 8'hFB);     // status read, lock=0

    // R8 held strobe: ignored while busy, taken at done
    push_exp(8'hA7, 1, 24'h5A0000, 1, 0, 8'h04);
    push_exp(8'h34, 0, 24'h0, 1, 1, 8'h04);
    want_resp = 1; tgt_resp = 8'h04;
    @(negedge clk);
    start = 1; cmd = 8'hA7; arg_cnt = 2'd1; args = 24'h5A0000; resp_en = 1; status = 0;
    @(negedge clk);
    cmd = 8'h34; arg_cnt = 2'd0; args = 24'h0; status = 1;
    wait_done();
    @(negedge clk);
    start = 0;
    chk(busy, "R8 accept in done cycle", busy, 1);
    wait_done();
    chk(exp_q.size() == 0, "R3 back-to-back bytes", exp_q.size(), 0);
    repeat (4) @(negedge clk);
    chk(done_q.size() == 0, "R8 completions", done_q.size(), 0);
    finish_run();
  end
endmodule